// File: doc/BRIEF.md
# Rank CKE Power-Down Controller

This block manages the clock-enable line of each DRAM rank behind one memory controller. For every rank it counts consecutive clocks without pending work. When the count reaches a programmable limit, it lowers that rank's CKE and places the rank in one of three power-down flavours. The flavours are active power-down, precharge power-down with the DLL kept running (fast exit), and precharge power-down with the DLL stopped (slow exit). A precharge flavour is taken only when every bank of the rank is closed. If any bank is open, the rank drops back to active power-down.

When a command becomes pending for a sleeping rank, CKE is raised on the next clock. The rank's command-allowed flag then stays low for a programmable exit latency of 3 to 5 clocks. After a slow exit, a separate data-allowed flag stays low for a longer, fixed gap, so the scheduler can issue non-data commands before the DLL has relocked.

A global self-refresh request overrides power-down. While it is raised, no rank starts a new power-down. As soon as every rank is quiet, all CKE lines fall on the same clock and stay low, whatever commands appear, until the request is withdrawn. All ranks then leave together.

Top module: `ckepd_ctrl`

## Requirements
- R1: After reset every rank has CKE high, command-allowed and data-allowed high, and DLL-off low.
- R2: A rank's CKE falls on the (idle_limit+1)-th consecutive clock edge at which its cmd_pending is low, provided sr_req is low. Any edge with cmd_pending high restarts that count from zero.
- R3: The pd_mode code sampled at entry selects the flavour: 0 and 3 give active power-down, 1 gives fast-exit precharge power-down, 2 gives slow-exit precharge power-down. dll_off is high only in the slow-exit flavour or in self-refresh.
- R4: If banks_open for the rank is high at entry, the rank uses active power-down whatever pd_mode says, so dll_off stays low.
- R5: A rank in power-down that sees cmd_pending high raises CKE on the next clock edge. Its cmd_ok then stays low for exactly L clock edges after that rise, where L is the effective exit latency.
- R6: The effective exit latency L is exit_lat clamped to the range 3 to 5. Codes 0 to 2 give 3, codes 6 and 7 give 5.
- R7: After a slow-exit power-down, data_ok rises DATA_GAP (default 16) clock edges after CKE rises. After active or fast-exit power-down, data_ok rises together with cmd_ok.
- R8: While sr_req is high, no rank begins power-down. On the first edge at which every rank is in the awake state or in power-down with cmd_pending low, all CKE lines are low, and with the default SR_DLL_OFF=1 all dll_off lines are high.
- R9: During self-refresh, cmd_pending has no effect and CKE stays low. On the first edge with sr_req low, all ranks raise CKE together. cmd_ok follows after L edges and data_ok after DATA_GAP edges (SR_DLL_OFF=1).
- R10: cmd_ok is never high for a rank whose CKE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | IDLE_W | Idle clocks before power-down entry |
| pd_mode | input | 2 | Power-down flavour code (0/3 active, 1 fast exit, 2 slow exit) |
| exit_lat | input | 3 | Requested exit latency in clocks, clamped to 3..5 |
| sr_req | input | 1 | Global self-refresh request |
| cmd_pending | input | NUM_RANKS | Per-rank command waiting |
| banks_open | input | NUM_RANKS | Per-rank: at least one bank open |
| cke | output | NUM_RANKS | Per-rank clock enable |
| dll_off | output | NUM_RANKS | Per-rank DLL stopped |
| cmd_ok | output | NUM_RANKS | Per-rank: a command may be issued |
| data_ok | output | NUM_RANKS | Per-rank: a data transfer may start |

## Verification
The assertions assume that the configuration inputs (idle_limit, pd_mode, exit_lat) change only while the rank they affect is awake with a command pending. They also assume that banks_open reflects the rank's true state at the edge where entry happens. The stimulus respects this by reprogramming only while every cmd_pending bit is held high. It drives all inputs on the falling edge, so no value changes near the edge at which the block samples it. Self-refresh is requested and withdrawn only between complete scenarios. This keeps the global override from cutting across a per-rank exit that is still being measured.

// File: rtl/ckepd_pkg.sv
package ckepd_pkg;

   typedef enum logic [2:0] {
      ST_AWAKE   = 3'd0,
      ST_PD_ACT  = 3'd1,
      ST_PD_FAST = 3'd2,
      ST_PD_SLOW = 3'd3,
      ST_EXIT    = 3'd4,
      ST_SELF    = 3'd5
   } ckepd_state_e;

   localparam logic [1:0] PDM_FAST = 2'd1;
   localparam logic [1:0] PDM_SLOW = 2'd2;

   localparam int unsigned LAT_MIN = 3;
   localparam int unsigned LAT_MAX = 5;
   localparam int unsigned LAT_W   = 3;

   // Keep the wake latency inside the legal window.
   function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
      if (raw < LAT_W'(LAT_MIN))
         return LAT_W'(LAT_MIN);
      else if (raw > LAT_W'(LAT_MAX))
         return LAT_W'(LAT_MAX);
      else
         return raw;
   endfunction

endpackage

// File: rtl/ckepd_sr_coord.sv
module ckepd_sr_coord #(
   parameter int unsigned NUM_RANKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sr_req,
   input  logic [NUM_RANKS-1:0] quiet,
   output logic                 sr_go,
   output logic                 sr_leave,
   output logic                 sr_on
);

   logic sr_on_q;

   assign sr_go    = sr_req && !sr_on_q && (&quiet);
   assign sr_leave = sr_on_q && !sr_req;
   assign sr_on    = sr_on_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr_on_q <= 1'b0;
      else if (sr_go)
         sr_on_q <= 1'b1;
      else if (sr_leave)
         sr_on_q <= 1'b0;
   end

   // R8: entry commits the global self-refresh state on the next edge
   a_r8_go_commits: assert property (@(posedge clk) disable iff (!rst_n)
      sr_go |=> sr_on_q);

   // R9: withdrawing the request ends self-refresh on the next edge
   a_r9_leave_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sr_leave |=> !sr_on_q);

endmodule

// File: rtl/ckepd_rank.sv
module ckepd_rank
   import ckepd_pkg::*;
#(
   parameter int unsigned IDLE_W     = 8,
   parameter int unsigned DATA_GAP   = 16,
   parameter bit          SR_DLL_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDLE_W-1:0] idle_limit,
   input  logic [1:0]        pd_mode,
   input  logic [LAT_W-1:0]  lat,
   input  logic              cmd_pending,
   input  logic              banks_open,
   input  logic              sr_req,
   input  logic              sr_go,
   input  logic              sr_leave,
   output logic              quiet_o,
   output logic              cke_o,
   output logic              dll_off_o,
   output logic              cmd_ok_o,
   output logic              data_ok_o
);

   localparam int unsigned GAP_W = $clog2(DATA_GAP + 1);
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(DATA_GAP);
   localparam logic [GAP_W-1:0] SR_GAP   = SR_DLL_OFF ? GAP_W'(DATA_GAP) : '0;

   initial begin : p_param_chk
      assert (DATA_GAP > LAT_MAX)
         else $error("DATA_GAP must exceed the longest exit latency");
      assert (IDLE_W >= 1)
         else $error("IDLE_W must be at least 1");
   end

   ckepd_state_e       st;
   ckepd_state_e       pd_target;
   logic [IDLE_W-1:0]  idle_cnt;
   logic [LAT_W-1:0]   exit_cnt;
   logic [GAP_W-1:0]   data_cnt;
   logic               asleep;

   // Flavour chosen at entry; open banks force active power-down.
   always_comb begin
      if (banks_open)
         pd_target = ST_PD_ACT;
      else if (pd_mode == PDM_FAST)
         pd_target = ST_PD_FAST;
      else if (pd_mode == PDM_SLOW)
         pd_target = ST_PD_SLOW;
      else
         pd_target = ST_PD_ACT;
   end

   assign asleep = (st == ST_PD_ACT) || (st == ST_PD_FAST) || (st == ST_PD_SLOW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_AWAKE;
         idle_cnt <= '0;
         exit_cnt <= '0;
         data_cnt <= '0;
      end else begin
         if (data_cnt != '0)
            data_cnt <= data_cnt - 1'b1;
         if (sr_go) begin
            st       <= ST_SELF;
            idle_cnt <= '0;
         end else begin
            case (st)
               ST_AWAKE: begin
                  if (cmd_pending)
                     idle_cnt <= '0;
                  else if (idle_cnt == idle_limit) begin
                     if (!sr_req) begin
                        st       <= pd_target;
                        idle_cnt <= '0;
                     end
                  end else
                     idle_cnt <= idle_cnt + 1'b1;
               end
               ST_PD_ACT, ST_PD_FAST, ST_PD_SLOW: begin
                  if (cmd_pending) begin
                     st       <= ST_EXIT;
                     exit_cnt <= lat;
                     data_cnt <= (st == ST_PD_SLOW) ? GAP_LOAD : '0;
                  end
               end
               ST_EXIT: begin
                  exit_cnt <= exit_cnt - 1'b1;
                  if (exit_cnt == LAT_W'(1))
                     st <= ST_AWAKE;
               end
               ST_SELF: begin
                  if (sr_leave) begin
                     st       <= ST_EXIT;
                     exit_cnt <= lat;
                     data_cnt <= SR_GAP;
                  end
               end
               default: st <= ST_AWAKE;
            endcase
         end
      end
   end

   assign cke_o     = (st == ST_AWAKE) || (st == ST_EXIT);
   assign cmd_ok_o  = (st == ST_AWAKE);
   assign data_ok_o = (st == ST_AWAKE) && (data_cnt == '0);
   assign quiet_o   = ((st == ST_AWAKE) || asleep) && !cmd_pending;

   generate
      if (SR_DLL_OFF) begin : g_sr_dll_stop
         assign dll_off_o = (st == ST_PD_SLOW) || (st == ST_SELF);
      end else begin : g_sr_dll_run
         assign dll_off_o = (st == ST_PD_SLOW);
      end
   endgenerate

   // R10: no command permission while the clock enable is low
   a_r10_no_cmd_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |-> !cmd_ok_o);

   // R5: the wake edge never carries command permission
   a_r5_wake_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> !cmd_ok_o);

   // R3: DLL is stopped only while the rank is not clocked
   a_r3_dll_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      dll_off_o |-> !cke_o);

   // R7: data permission implies command permission
   a_r7_data_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      data_ok_o |-> cmd_ok_o);

   // R6: the wake counter stays inside the clamped window
   a_r6_lat_window: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXIT) |-> (exit_cnt >= LAT_W'(1) && exit_cnt <= LAT_W'(LAT_MAX)));

   // R9: pending commands do not wake a rank in self-refresh
   a_r9_self_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SELF && !sr_leave) |=> (st == ST_SELF));

   // R8: no fresh power-down entry while self-refresh is requested
   a_r8_no_entry_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AWAKE && sr_req) |=> (st == ST_AWAKE || st == ST_SELF));

endmodule

// File: rtl/ckepd_ctrl.sv
module ckepd_ctrl
   import ckepd_pkg::*;
#(
   parameter int unsigned NUM_RANKS  = 4,
   parameter int unsigned IDLE_W     = 8,
   parameter int unsigned DATA_GAP   = 16,
   parameter bit          SR_DLL_OFF = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDLE_W-1:0]    idle_limit,
   input  logic [1:0]           pd_mode,
   input  logic [2:0]           exit_lat,
   input  logic                 sr_req,
   input  logic [NUM_RANKS-1:0] cmd_pending,
   input  logic [NUM_RANKS-1:0] banks_open,
   output logic [NUM_RANKS-1:0] cke,
   output logic [NUM_RANKS-1:0] dll_off,
   output logic [NUM_RANKS-1:0] cmd_ok,
   output logic [NUM_RANKS-1:0] data_ok
);

   initial begin : p_param_chk
      assert (NUM_RANKS >= 1)
         else $error("NUM_RANKS must be at least 1");
   end

   logic [LAT_W-1:0]     lat_eff;
   logic [NUM_RANKS-1:0] quiet;
   logic                 sr_go;
   logic                 sr_leave;
   logic                 sr_on;

   assign lat_eff = clamp_lat(exit_lat);

   ckepd_sr_coord #(
      .NUM_RANKS (NUM_RANKS)
   ) u_sr (
      .clk      (clk),
      .rst_n    (rst_n),
      .sr_req   (sr_req),
      .quiet    (quiet),
      .sr_go    (sr_go),
      .sr_leave (sr_leave),
      .sr_on    (sr_on)
   );

   generate
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
         ckepd_rank #(
            .IDLE_W     (IDLE_W),
            .DATA_GAP   (DATA_GAP),
            .SR_DLL_OFF (SR_DLL_OFF)
         ) u_rank (
            .clk         (clk),
            .rst_n       (rst_n),
            .idle_limit  (idle_limit),
            .pd_mode     (pd_mode),
            .lat         (lat_eff),
            .cmd_pending (cmd_pending[r]),
            .banks_open  (banks_open[r]),
            .sr_req      (sr_req),
            .sr_go       (sr_go),
            .sr_leave    (sr_leave),
            .quiet_o     (quiet[r]),
            .cke_o       (cke[r]),
            .dll_off_o   (dll_off[r]),
            .cmd_ok_o    (cmd_ok[r]),
            .data_ok_o   (data_ok[r])
         );
      end
   endgenerate

   // R8: every rank is unclocked while self-refresh is active
   a_r8_all_low_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
      sr_on |-> (cke == '0));

   // R8: entry lowers all clock enables on the same edge
   a_r8_enter_together: assert property (@(posedge clk) disable iff (!rst_n)
      sr_go |=> (cke == '0));

   // R9: leaving self-refresh wakes all ranks on the same edge
   a_r9_leave_together: assert property (@(posedge clk) disable iff (!rst_n)
      sr_leave |=> (cke == '1 && cmd_ok == '0));

endmodule

// File: tb/ckepd_ctrl_test.sv
module ckepd_ctrl_test;

   localparam int PERIOD = 10;
   localparam int NR     = 4;
   localparam int GAP    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    idle_limit = 8'd4;
   logic [1:0]    pd_mode = 2'd0;
   logic [2:0]    exit_lat = 3'd3;
   logic          sr_req = 1'b0;
   logic [NR-1:0] cmd_pending = '1;
   logic [NR-1:0] banks_open = '0;
   logic [NR-1:0] cke, dll_off, cmd_ok, data_ok;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ckepd_ctrl uut (
      .clk (clk), .rst_n (rst_n), .idle_limit (idle_limit), .pd_mode (pd_mode),
      .exit_lat (exit_lat), .sr_req (sr_req), .cmd_pending (cmd_pending),
      .banks_open (banks_open), .cke (cke), .dll_off (dll_off),
      .cmd_ok (cmd_ok), .data_ok (data_ok)
   );

   // mode[22:21] open[20] lat[19:17] idle[16:9] exp_dll[8] exp_cmd[7:5] exp_data[4:0]
   localparam int NV = 9;
   localparam logic [22:0] VEC [0:NV-1] = '{
      {2'd0, 1'b0, 3'd3, 8'd4,  1'b0, 3'd3, 5'd3},
      {2'd1, 1'b0, 3'd4, 8'd2,  1'b0, 3'd4, 5'd4},
      {2'd2, 1'b0, 3'd5, 8'd0,  1'b1, 3'd5, 5'd16},
      {2'd2, 1'b1, 3'd3, 8'd6,  1'b0, 3'd3, 5'd3},
      {2'd1, 1'b1, 3'd5, 8'd1,  1'b0, 3'd5, 5'd5},
      {2'd3, 1'b0, 3'd4, 8'd3,  1'b0, 3'd4, 5'd4},
      {2'd2, 1'b0, 3'd1, 8'd5,  1'b1, 3'd3, 5'd16},
      {2'd0, 1'b0, 3'd7, 8'd1,  1'b0, 3'd5, 5'd5},
      {2'd2, 1'b0, 3'd0, 8'd10, 1'b1, 3'd3, 5'd16}
   };

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
   endtask

   initial begin : watchdog
      #(PERIOD * 150000);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         summary();
         $finish;
      end
   end

   initial begin : main
      int n;
      int m;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1: reset state
      chk("R1 cke", int'(cke), 15);
      chk("R1 cmd_ok", int'(cmd_ok), 15);
      chk("R1 data_ok", int'(data_ok), 15);
      chk("R1 dll_off", int'(dll_off), 0);

      for (int i = 0; i < NV; i++) begin
         cmd_pending   = '1;
         pd_mode       = VEC[i][22:21];
         banks_open[0] = VEC[i][20];
         exit_lat      = VEC[i][19:17];
         idle_limit    = VEC[i][16:9];
         step(2);
         cmd_pending[0] = 1'b0;
         n = 0;
         for (int k = 0; k < 300; k++) begin
            step(1);
            n++;
            if (!cke[0]) break;
         end
         chk("R2 entry edge", n, int'(VEC[i][16:9]) + 1);
         chk("R3/R4 dll_off", int'(dll_off[0]), int'(VEC[i][8]));
         chk("R10 cmd_ok while asleep", int'(cmd_ok[0]), 0);
         step(2);
         chk("R5 stays asleep", int'(cke[0]), 0);
         cmd_pending[0] = 1'b1;
         step(1);
         chk("R5 wake next edge", int'(cke[0]), 1);
         n = 0;
         for (int k = 0; k < 40 && !cmd_ok[0]; k++) begin
            step(1);
            n++;
         end
         chk("R5/R6 exit latency", n, int'(VEC[i][7:5]));
         m = n;
         for (int k = 0; k < 40 && !data_ok[0]; k++) begin
            step(1);
            m++;
         end
         chk("R7 data gap", m, int'(VEC[i][4:0]));
      end

      // R2: a pending command in mid-count restarts the idle count
      cmd_pending = '1; banks_open = '0; pd_mode = 2'd0; exit_lat = 3'd3; idle_limit = 8'd4;
      step(2);
      cmd_pending[0] = 1'b0;
      step(2);
      cmd_pending[0] = 1'b1;
      step(1);
      chk("R2 interrupted stays awake", int'(cke[0]), 1);
      cmd_pending[0] = 1'b0;
      n = 0;
      for (int k = 0; k < 50; k++) begin
         step(1);
         n++;
         if (!cke[0]) break;
      end
      chk("R2 restart count", n, 5);
      cmd_pending[0] = 1'b1;
      for (int k = 0; k < 20 && !cmd_ok[0]; k++) step(1);

      // R8: one rank already asleep, others held awake by the request
      idle_limit = 8'd3; exit_lat = 3'd4;
      cmd_pending = 4'b1110;
      step(5);
      chk("R8 rank0 asleep before request", int'(cke[0]), 0);
      sr_req = 1'b1;
      step(1);
      cmd_pending = 4'b0010;
      step(8);
      chk("R8 no entry while requested", int'(cke), 14);
      cmd_pending = 4'b0000;
      step(1);
      chk("R8 all cke low together", int'(cke), 0);
      chk("R8 dll_off in self-refresh", int'(dll_off), 15);
      chk("R10 cmd_ok in self-refresh", int'(cmd_ok), 0);
      cmd_pending[2] = 1'b1;
      step(5);
      chk("R9 pending ignored", int'(cke), 0);
      idle_limit = 8'd60;
      cmd_pending = '1;
      sr_req = 1'b0;
      step(1);
      chk("R9 all wake together", int'(cke), 15);
      chk("R9 cmd blocked on wake", int'(cmd_ok), 0);
      n = 0;
      for (int k = 0; k < 40 && cmd_ok != 4'hF; k++) begin
         step(1);
         n++;
      end
      chk("R9 exit latency", n, 4);
      m = n;
      for (int k = 0; k < 40 && data_ok != 4'hF; k++) begin
         step(1);
         m++;
      end
      chk("R9 data gap", m, GAP);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule